// File: doc/BRIEF.md
# Memory-Mapped Flash Read Translator

This block lets a serial flash device appear as plain read-only memory. A bus read that falls into the flash address range becomes a complete serial read transaction on the flash pins: the matching chip select goes low, an 8-bit read opcode goes out, followed by the flash address and an optional run of dummy clocks. Data bytes are then clocked in and one 32-bit word is returned to the requester with a valid/ready handshake.

A single 32-bit setup word controls every mapped read. It holds the opcode, the lane mode, the address length, the dummy count and the fetch length. Once its lock bit is set, the word can no longer change until reset. The bus address space is split into equal windows of 2^WIN_BITS bytes, one window for each chip select. The bits above the window offset pick the device, and the offset inside the window becomes the flash address.

Top module: `flash_map_reader`

## Requirements
- R1: The setup word resets to 0x0000_0003. A write stores all 32 bits, and those bits read back on `cfg_rdata`. The fields are: opcode in bits 7:0, lane mode in bits 9:8, dummy byte count in bits 13:12, address length in bits 17:16, fetch length in bits 25:24 and lock in bit 31.
- R2: Once bit 31 of the stored setup word is 1, every further write is ignored until reset.
- R3: The chip select index is `req_addr[WIN_BITS +: 2]`. During a transaction only that `fl_cs_n` bit is low. When the block is idle, all `fl_cs_n` bits are high and `fl_sck` is low. Each serial clock period lasts two system clocks: low first, then high.
- R4: For lane modes 0, 1 and 2, the opcode is sent first, MSB first, as 8 beats on `fl_io_out[0]` with only `fl_io_oe[0]` set. Lane mode 3 is a pass-through mode that sends no opcode.
- R5: The address follows, MSB first. An address length of 0 sends 3 bytes, carrying the low 24 bits of the aligned offset. Any other value sends 4 bytes. The lane mode sets the lane count: mode 0 and mode 3 use 1 lane on io[0]; mode 1 uses 2 lanes on io[1:0], with io[1] carrying the higher bit; mode 2 uses 4 lanes on io[3:0], with io[3] carrying the highest bit. Only the lanes in use are driven.
- R6: The dummy count D (0..3) adds D*8/lanes serial clocks, during which no lane is driven.
- R7: Read data uses the same lane count and arrives MSB first. In single-lane modes it is sampled on io[1]. In mode 1 it is sampled on io[1:0], and in mode 2 on io[3:0]. Each sample is taken at the end of the high half of the serial clock.
- R8: A fetch length of 3 reads the whole 16-byte-aligned line that holds the requested address. Any other value reads only the 4-byte-aligned word.
- R9: The returned word is little-endian: the byte at the lowest flash address sits in bits 7:0. `rsp_valid` and `rsp_data` hold steady until `rsp_ready`. `req_ready` is low from the moment a request is accepted until the response has been taken.
- R10: The setup word is captured when a request is accepted. A setup write in that same cycle affects only later transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Setup word write strobe |
| cfg_wdata | input | 32 | Setup word write value |
| cfg_rdata | output | 32 | Stored setup word |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted in this cycle when valid |
| req_addr | input | WIN_BITS+2 | Byte address: chip select index above the window offset |
| rsp_valid | output | 1 | Read word available |
| rsp_ready | input | 1 | Requester takes the word |
| rsp_data | output | 32 | Returned word |
| fl_sck | output | 1 | Serial flash clock |
| fl_cs_n | output | NUM_CS | Active-low chip selects |
| fl_io_out | output | 4 | Lane output values |
| fl_io_oe | output | 4 | Lane output enables |
| fl_io_in | input | 4 | Lane input values |

## Verification
Two events can land in the same clock cycle: a setup-word write and the acceptance of a bus read. The bench provokes this by raising `cfg_we` with a new opcode in exactly the cycle where `req_valid` meets `req_ready`. The flash model must then capture the old opcode, `cfg_rdata` must already show the new word, and the next read must carry the new opcode. Around this case, a sweep runs every lane mode, address length, dummy count and both fetch lengths across all four chip selects. A bench flash model checks each transaction: opcode, address, beat count and lane enables per phase, plus the returned word computed from an arithmetic byte pattern.

// File: rtl/flash_map_pkg.sv
// Shared types for the memory-mapped flash read translator.
// Assumes the setup word layout listed in the brief (R1).
package flash_map_pkg;

    typedef enum logic [1:0] {
        LANE_X1  = 2'd0,
        LANE_X2  = 2'd1,
        LANE_X4  = 2'd2,
        LANE_RAW = 2'd3
    } lane_mode_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_RESP
    } seq_state_e;

    typedef struct packed {
        logic [1:0] burst;
        logic [1:0] asz;
        logic [1:0] dummy;
        lane_mode_e mode;
        logic [7:0] opcode;
    } rd_cfg_t;

    localparam logic [31:0] CFG_RESET = 32'h0000_0003;

    // Unpack the fields that drive a transaction from the stored word.
    function automatic rd_cfg_t cfg_decode(input logic [31:0] w);
        rd_cfg_t c;
        c.burst  = w[25:24];
        c.asz    = w[17:16];
        c.dummy  = w[13:12];
        c.mode   = lane_mode_e'(w[9:8]);
        c.opcode = w[7:0];
        return c;
    endfunction

    // log2 of the lane count used by the address, dummy and data phases.
    function automatic logic [1:0] lane_log2(input lane_mode_e m);
        case (m)
            LANE_X2: return 2'd1;
            LANE_X4: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/flash_map_cfg.sv
// Setup word register with a sticky lock bit.
// Assumes bit 31 is the lock; once it is set, writes are dropped until reset.
module flash_map_cfg
    import flash_map_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] word
);

    // Hold the setup word; refuse updates once locked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= CFG_RESET;
        else if (we && !word[31])
            word <= wdata;
    end

endmodule

// File: rtl/flash_map_pick.sv
// Selects the requested 32-bit word from the shifted-in fetch buffer.
// Assumes byte 0 of a line lands in bits 127:120 after a 16-byte fetch, and
// byte 0 of a word fetch lands in bits 31:24 (the slot of line byte 12).
module flash_map_pick (
    input  logic [127:0] line,
    input  logic         line_mode,
    input  logic [1:0]   wsel,
    output logic [31:0]  word
);

    // Gather four consecutive bytes, lowest address into the low lane.
    always_comb begin
        word = '0;
        for (int i = 0; i < 4; i++) begin
            logic [3:0] bidx;
            bidx = line_mode ? ({wsel, 2'b00} + 4'(i)) : (4'd12 + 4'(i));
            word[8*i +: 8] = line[(15 - int'(bidx)) * 8 +: 8];
        end
    end

endmodule

// File: rtl/flash_map_seq.sv
// Burst sequencer: accepts one read, walks opcode, address, dummy and data
// phases on the serial pins, then offers the response.
// Assumes the setup word is stable only at acceptance; it is captured then.
// One serial clock period is two system clocks (low half, high half).
module flash_map_seq
    import flash_map_pkg::*;
#(
    parameter int WIN_BITS = 27,
    parameter int CS_BITS  = 2,
    parameter int NUM_CS   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  rd_cfg_t                     cfg,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [WIN_BITS+CS_BITS-1:0] req_addr,
    output logic                        rsp_valid,
    input  logic                        rsp_ready,
    output logic [127:0]                line_buf,
    output logic                        line_mode,
    output logic [1:0]                  wsel,
    output logic                        sck,
    output logic [NUM_CS-1:0]           cs_n,
    output logic [3:0]                  io_out,
    output logic [3:0]                  io_oe,
    input  logic [3:0]                  io_in
);

    seq_state_e           state;
    rd_cfg_t              cur;
    logic                 ph;
    logic [7:0]           cnt;
    logic [CS_BITS-1:0]   sel;
    logic [31:0]          off_q;
    logic [31:0]          out_sr;
    logic [31:0]          off_w;
    logic [31:0]          aligned;
    logic [1:0]           lg;
    logic [7:0]           n_addr, n_dummy, n_data;
    logic                 active;

    // Place a flash address MSB-aligned in the output shifter.
    function automatic logic [31:0] addr_load(input logic [31:0] a, input logic four);
        return four ? a : {a[23:0], 8'h00};
    endfunction

    // Decode window offset and align it to the fetch length of the live setup.
    always_comb begin
        off_w   = 32'(req_addr[WIN_BITS-1:0]);
        aligned = off_w & ((cfg.burst == 2'd3) ? ~32'hF : ~32'h3);
    end

    // Beat counts of each phase for the captured setup.
    always_comb begin
        lg      = lane_log2(cur.mode);
        n_addr  = ((cur.asz != 2'd0) ? 8'd32 : 8'd24) >> lg;
        n_dummy = {3'b000, cur.dummy, 3'b000} >> lg;
        n_data  = (line_mode ? 8'd128 : 8'd32) >> lg;
    end

    assign line_mode = (cur.burst == 2'd3);
    assign active    = (state == S_CMD) || (state == S_ADDR) ||
                       (state == S_DUMMY) || (state == S_DATA);
    assign req_ready = (state == S_IDLE);
    assign rsp_valid = (state == S_RESP);
    assign sck       = ph;

    // Main sequence: capture, shift out, shift in, hand over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cur      <= '0;
            ph       <= 1'b0;
            cnt      <= '0;
            sel      <= '0;
            off_q    <= '0;
            wsel     <= '0;
            out_sr   <= '0;
            line_buf <= '0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    cur   <= cfg;
                    sel   <= req_addr[WIN_BITS +: CS_BITS];
                    off_q <= aligned;
                    wsel  <= req_addr[3:2];
                    cnt   <= '0;
                    ph    <= 1'b0;
                    if (cfg.mode == LANE_RAW) begin
                        state  <= S_ADDR;
                        out_sr <= addr_load(aligned, cfg.asz != 2'd0);
                    end else begin
                        state  <= S_CMD;
                        out_sr <= {cfg.opcode, 24'h0};
                    end
                end
                S_RESP: if (rsp_ready) state <= S_IDLE;
                default: begin
                    ph <= ~ph;
                    if (ph) begin
                        cnt <= cnt + 8'd1;
                        case (state)
                            S_CMD: begin
                                out_sr <= out_sr << 1;
                                if (cnt == 8'd7) begin
                                    state  <= S_ADDR;
                                    cnt    <= '0;
                                    out_sr <= addr_load(off_q, cur.asz != 2'd0);
                                end
                            end
                            S_ADDR: begin
                                out_sr <= out_sr << (6'd1 << lg);
                                if (cnt == n_addr - 8'd1) begin
                                    cnt   <= '0;
                                    state <= (n_dummy != 8'd0) ? S_DUMMY : S_DATA;
                                end
                            end
                            S_DUMMY: if (cnt == n_dummy - 8'd1) begin
                                cnt   <= '0;
                                state <= S_DATA;
                            end
                            S_DATA: begin
                                case (lg)
                                    2'd0:    line_buf <= {line_buf[126:0], io_in[1]};
                                    2'd1:    line_buf <= {line_buf[125:0], io_in[1:0]};
                                    default: line_buf <= {line_buf[123:0], io_in[3:0]};
                                endcase
                                if (cnt == n_data - 8'd1) begin
                                    cnt   <= '0;
                                    state <= S_RESP;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end

    // Lane drive: opcode on one lane, address on the mode's lanes, else float.
    always_comb begin
        io_out = '0;
        io_oe  = '0;
        case (state)
            S_CMD: begin
                io_oe  = 4'b0001;
                io_out = {3'b000, out_sr[31]};
            end
            S_ADDR: case (lg)
                2'd0: begin
                    io_oe  = 4'b0001;
                    io_out = {3'b000, out_sr[31]};
                end
                2'd1: begin
                    io_oe  = 4'b0011;
                    io_out = {2'b00, out_sr[31:30]};
                end
                default: begin
                    io_oe  = 4'b1111;
                    io_out = out_sr[31:28];
                end
            endcase
            default: ;
        endcase
    end

    // One active-low select per device window.
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = !(active && (sel == CS_BITS'(i)));
    end

endmodule

// File: rtl/flash_map_reader.sv
// Top of the memory-mapped flash read translator: setup register, burst
// sequencer and word picker. Assumes NUM_CS is a power of two so every
// address hits a window.
module flash_map_reader
    import flash_map_pkg::*;
#(
    parameter int WIN_BITS = 27,
    parameter int NUM_CS   = 4,
    localparam int CS_BITS = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int ADDR_W  = WIN_BITS + CS_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [31:0]       rsp_data,
    output logic              fl_sck,
    output logic [NUM_CS-1:0] fl_cs_n,
    output logic [3:0]        fl_io_out,
    output logic [3:0]        fl_io_oe,
    input  logic [3:0]        fl_io_in
);

    logic [127:0] line_buf;
    logic         line_mode;
    logic [1:0]   wsel;
    rd_cfg_t      cfg_f;

    assign cfg_f = cfg_decode(cfg_rdata);

    flash_map_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .word  (cfg_rdata)
    );

    flash_map_seq #(
        .WIN_BITS (WIN_BITS),
        .CS_BITS  (CS_BITS),
        .NUM_CS   (NUM_CS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg_f),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .line_buf  (line_buf),
        .line_mode (line_mode),
        .wsel      (wsel),
        .sck       (fl_sck),
        .cs_n      (fl_cs_n),
        .io_out    (fl_io_out),
        .io_oe     (fl_io_oe),
        .io_in     (fl_io_in)
    );

    flash_map_pick u_pick (
        .line      (line_buf),
        .line_mode (line_mode),
        .wsel      (wsel),
        .word      (rsp_data)
    );

endmodule

// File: rtl/flash_map_reader_chk.sv
// Port-level checker for flash_map_reader, attached with bind below.
module flash_map_reader_chk #(
    parameter int WIN_BITS = 27,
    parameter int NUM_CS   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       cfg_rdata,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [31:0]       rsp_data,
    input logic              fl_sck,
    input logic [NUM_CS-1:0] fl_cs_n
);

    // R3: never more than one device selected.
    assert_one_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~fl_cs_n));

    // R3: serial clock rests low while no device is selected.
    assert_sck_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (&fl_cs_n) |-> !fl_sck);

    // R2: a locked setup word never changes.
    assert_lock_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[31] |=> $stable(cfg_rdata));

    // R9: a pending response holds its word.
    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R9: no new request is taken while a response waits.
    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

endmodule

bind flash_map_reader flash_map_reader_chk #(
    .WIN_BITS (WIN_BITS),
    .NUM_CS   (NUM_CS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rdata (cfg_rdata),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .fl_sck    (fl_sck),
    .fl_cs_n   (fl_cs_n)
);

// File: tb/tb_flash_map_reader.sv
module tb_flash_map_reader;

    localparam int WIN_BITS = 27;
    localparam int NUM_CS   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [28:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_data;
    logic        fl_sck;
    logic [3:0]  fl_cs_n;
    logic [3:0]  fl_io_out, fl_io_oe;
    logic [3:0]  fl_io_in = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    flash_map_reader #(.WIN_BITS(WIN_BITS), .NUM_CS(NUM_CS)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .fl_sck(fl_sck), .fl_cs_n(fl_cs_n),
        .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe), .fl_io_in(fl_io_in)
    );

    // Setup the model expects for the burst in flight.
    int e_mode = 0, e_asz = 0, e_dum = 0, e_burst = 0;

    // Flash model state.
    int          m_beat;
    int          m_cs;
    bit          m_bad;
    logic [7:0]  m_op;
    logic [31:0] m_addr;
    wire         cs_any = ~&fl_cs_n;

    function automatic logic [7:0] fbyte(input int cs, input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'(cs * 8'h37) ^ 8'hA5;
    endfunction

    function automatic int lanes_of(input int mode);
        return (mode == 1) ? 2 : (mode == 2) ? 4 : 1;
    endfunction

    function automatic int cmd_beats(input int mode);
        return (mode == 3) ? 0 : 8;
    endfunction

    function automatic int addr_beats(input int mode, input int asz);
        return ((asz != 0) ? 32 : 24) / lanes_of(mode);
    endfunction

    function automatic int dum_beats(input int mode, input int dum);
        return dum * 8 / lanes_of(mode);
    endfunction

    always @(posedge cs_any) begin
        m_beat = 0; m_bad = 0; m_op = '0; m_addr = '0; m_cs = -1;
        for (int i = 0; i < NUM_CS; i++) if (!fl_cs_n[i]) m_cs = i;
    end

    always @(posedge fl_sck) begin
        int L, c, a, d, k, p, sh;
        logic [7:0] by, v;
        logic [3:0] lm;
        L = lanes_of(e_mode);
        c = cmd_beats(e_mode);
        a = addr_beats(e_mode, e_asz);
        d = dum_beats(e_mode, e_dum);
        lm = (L == 1) ? 4'b0001 : (L == 2) ? 4'b0011 : 4'b1111;
        if (m_beat < c) begin
            m_op = {m_op[6:0], fl_io_out[0]};
            if (fl_io_oe != 4'b0001) m_bad = 1;
        end else if (m_beat < c + a) begin
            if (L == 1) m_addr = {m_addr[30:0], fl_io_out[0]};
            else if (L == 2) m_addr = {m_addr[29:0], fl_io_out[1:0]};
            else m_addr = {m_addr[27:0], fl_io_out};
            if (fl_io_oe != lm) m_bad = 1;
        end else begin
            if (fl_io_oe != 4'b0000) m_bad = 1;
            if (m_beat >= c + a + d) begin
                k = m_beat - (c + a + d);
                p = k * L;
                by = fbyte(m_cs, m_addr + 32'(p / 8));
                sh = 8 - L - (p % 8);
                v = by >> sh;
                if (L == 1) fl_io_in = {2'b00, v[0], 1'b0};
                else if (L == 2) fl_io_in = {2'b00, v[1:0]};
                else fl_io_in = v[3:0];
            end
        end
        m_beat = m_beat + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic expect_cfg(input logic [31:0] v);
        e_mode = int'(v[9:8]);
        e_asz = int'(v[17:16]);
        e_dum = int'(v[13:12]);
        e_burst = int'(v[25:24]);
    endtask

    // One mapped read with full checking; optionally writes the setup word in
    // the acceptance cycle (R10).
    task automatic do_read(input int cs, input logic [31:0] off, input logic [7:0] exp_op,
                           input bit with_wr, input logic [31:0] wv);
        logic [31:0] ea, ew, held;
        int tmo, tot;
        bit line;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = {2'(cs), off[26:0]};
        if (with_wr) begin
            cfg_we = 1'b1;
            cfg_wdata = wv;
        end
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b0;
        check(req_ready == 1'b0, "R9 busy after accept", 32'(req_ready), 32'h0);
        tmo = 0;
        while (!rsp_valid && tmo < 2000) begin
            @(negedge clk);
            tmo++;
        end
        check(rsp_valid == 1'b1, "R9 response arrives", 32'(rsp_valid), 32'h1);
        line = (e_burst == 3);
        ea = {5'b0, off[26:0]} & (line ? ~32'hF : ~32'h3);
        if (e_asz == 0) ea = ea & 32'h00FF_FFFF;
        if (e_mode != 3)
            check(m_op == exp_op, "R4 opcode", 32'(m_op), 32'(exp_op));
        check(m_addr == ea, "R5 R8 flash address", m_addr, ea);
        check(m_cs == cs, "R3 chip select", 32'(m_cs), 32'(cs));
        check(m_bad == 0, "R5 R6 lane enables per phase", 32'(m_bad), 32'h0);
        tot = cmd_beats(e_mode) + addr_beats(e_mode, e_asz) + dum_beats(e_mode, e_dum) +
              (line ? 128 : 32) / lanes_of(e_mode);
        check(m_beat == tot, "R6 R8 serial clock count", 32'(m_beat), 32'(tot));
        for (int i = 0; i < 4; i++)
            ew[8*i +: 8] = fbyte(cs, ea + (line ? 32'(off[3:2]) * 4 : 32'h0) + 32'(i));
        check(rsp_data == ew, "R7 R9 returned word", rsp_data, ew);
        held = rsp_data;
        repeat (3) @(negedge clk);
        check(rsp_valid && rsp_data == held, "R9 response held", rsp_data, held);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(!rsp_valid && req_ready && (&fl_cs_n), "R3 R9 return to idle",
              {28'h0, fl_cs_n}, 32'hF);
    endtask

    initial begin
        logic [31:0] v, off;
        int it;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_rdata == 32'h0000_0003, "R1 reset value", cfg_rdata, 32'h3);
        check(&fl_cs_n && !fl_sck && req_ready && !rsp_valid, "R3 idle pins",
              {28'h0, fl_cs_n}, 32'hF);
        set_cfg(32'h7FFF_FFFF);
        check(cfg_rdata == 32'h7FFF_FFFF, "R1 readback", cfg_rdata, 32'h7FFF_FFFF);

        // Sweep of all lane modes, address lengths, dummy counts, fetch lengths.
        it = 0;
        for (int mode = 0; mode < 4; mode++)
            for (int asz = 0; asz < 2; asz++)
                for (int dum = 0; dum < 4; dum++)
                    for (int bi = 0; bi < 2; bi++) begin
                        v = {6'h0, (bi != 0) ? 2'd3 : 2'd0, 6'h0, 2'(asz), 2'h0,
                             2'(dum), 2'h0, 2'(mode), 8'(8'h0B + it)};
                        set_cfg(v);
                        expect_cfg(v);
                        off = (32'(it) * 32'h00A3_C5E7 + 32'h0123_4567) & 32'h07FF_FFFF;
                        do_read(it % 4, off, v[7:0], 1'b0, 32'h0);
                        it++;
                    end

        // R10: setup write in the cycle a request is accepted.
        v = 32'h0300_003B;
        set_cfg(v);
        expect_cfg(v);
        do_read(2, 32'h0456_7894, 8'h3B, 1'b1, 32'h0300_006B);
        check(cfg_rdata == 32'h0300_006B, "R10 new word stored", cfg_rdata, 32'h0300_006B);
        do_read(1, 32'h0000_0040, 8'h6B, 1'b0, 32'h0);

        // R2: lock, then attempt to overwrite.
        v = 32'h8001_2203;
        set_cfg(v);
        expect_cfg(v);
        check(cfg_rdata == v, "R2 lock written", cfg_rdata, v);
        set_cfg(32'h0000_00EB);
        check(cfg_rdata == v, "R2 write ignored when locked", cfg_rdata, v);
        do_read(3, 32'h0765_4321, 8'h03, 1'b0, 32'h0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule